// File: doc/BRIEF.md
# Pipelined Unsigned Divide-by-Ten

This block divides an unsigned word by the fixed constant ten. It uses only shifts and additions, with no multiplier and no general divider. A new operand can be presented on every clock cycle with a valid strobe. After a fixed number of cycles the block returns the exact quotient and the remainder with a matching valid strobe. There is no back-pressure: every accepted operand produces exactly one result, and results leave in the order the operands arrived.

The operand first goes through a short shift-add chain. The recurring binary fraction 0.1100 1100… is eight tenths, so the chain scales the operand by that fraction. The seed is the operand shifted right by one plus the operand shifted right by two. The seed is then refined three times. Each refinement adds to the running value a copy of itself shifted right by 4, then 8, then 16. The refined value shifted right by three is a quotient estimate that can fall short by one. A correction stage multiplies the estimate back by ten, again with shifts, to form the remainder. If that remainder is ten or more, the stage raises the quotient by one and lowers the remainder by ten. Each adder step has its own pipeline register, and a valid bit travels with the data.

Top module: `div10_pipe`

## Requirements
- R1: Whenever `res_valid` is high, `res_quot` equals the floor of the matching operand divided by ten, for every 32-bit unsigned operand.
- R2: Whenever `res_valid` is high, `res_rem` equals the operand modulo ten and so lies in 0 to 9.
- R3: An operand sampled with `op_valid` high at a rising edge, counted as edge 1, yields `res_valid` high straight after rising edge 6. Operands accepted on consecutive cycles give results on consecutive cycles.
- R4: A rising edge at which `op_valid` is low yields no result: `res_valid` stays low right after the sixth edge counted from that one.
- R5: With `rst` high at a rising edge, all in-flight valid bits clear. `res_valid` is low after that edge, and operands already in flight never produce a result.
- R6: Results come out in the order their operands were accepted.
- R7: Boundary operands give exact results. 0 gives 0 remainder 0. 9 gives 0 remainder 9. 10 gives 1 remainder 0. 99 gives 9 remainder 9. 100 gives 10 remainder 0. 4294967295 gives 429496729 remainder 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset of the valid pipeline |
| op_valid | input | 1 | Operand strobe |
| op_data | input | 32 | Unsigned dividend |
| res_valid | output | 1 | Result strobe |
| res_quot | output | 32 | Quotient, operand divided by ten |
| res_rem | output | 4 | Remainder, 0 to 9 |

## Verification
Every result is due right after the sixth rising edge, counting the edge that captures its operand as the first. The driver stamps each expected item with that edge number when it pushes it into the scoreboard. The monitor samples at the falling edge. When the head item is due, the monitor requires `res_valid` together with the exact quotient and remainder. At every other falling edge it requires `res_valid` low. A result that comes early, comes late, is missing or is extra therefore fails. Reset is applied with operands in flight, and those items are dropped from the scoreboard, so any stray result is caught.

// File: rtl/div10_pkg.sv
package div10_pkg;

    // Default operand width.
    parameter int unsigned DIV_W_DEF = 32;

    // Constant divisor and remainder width.
    localparam int unsigned DIVISOR = 10;
    localparam int unsigned REM_W   = 4;

    // A remainder estimate stays below twice the divisor: one extra bit.
    localparam int unsigned REM_EST_W = REM_W + 1;

    // Number of doubling refinement steps: shifts 4, 8, 16, ... below width.
    function automatic int unsigned refine_steps(input int unsigned width);
        return $clog2(width) - 2;
    endfunction

endpackage

// File: rtl/div10_seed.sv
module div10_seed
    import div10_pkg::*;
#(
    parameter int unsigned W = DIV_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_num,
    output logic         out_valid,
    output logic [W-1:0] out_num,
    output logic [W-1:0] out_part
);

    logic [W-1:0] seed_val;

    // Three quarters of the operand starts the eight-tenths estimate.
    always_comb begin
        seed_val = (in_num >> 1) + (in_num >> 2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        out_num  <= in_num;
        out_part <= seed_val;
    end

endmodule

// File: rtl/div10_refine.sv
module div10_refine
    import div10_pkg::*;
#(
    parameter int unsigned W     = DIV_W_DEF,
    parameter int unsigned SHIFT = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_num,
    input  logic [W-1:0] in_part,
    output logic         out_valid,
    output logic [W-1:0] out_num,
    output logic [W-1:0] out_part
);

    logic [W-1:0] grown;

    // Doubles the number of correct fraction bits in the estimate.
    always_comb begin
        grown = in_part + (in_part >> SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        out_num  <= in_num;
        out_part <= grown;
    end

endmodule

// File: rtl/div10_fix.sv
module div10_fix
    import div10_pkg::*;
#(
    parameter int unsigned W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [W-1:0]     in_num,
    input  logic [W-1:0]     in_part,
    output logic             out_valid,
    output logic [W-1:0]     out_quot,
    output logic [REM_W-1:0] out_rem
);

    // Stage A: estimate the quotient and the remainder it leaves.
    logic [W-1:0]         est_q;
    logic [W-1:0]         est_back;
    logic [W-1:0]         est_diff;
    logic                 a_valid;
    logic [W-1:0]         a_quot;
    logic [REM_EST_W-1:0] a_rem;

    always_comb begin
        est_q    = in_part >> 3;
        est_back = (est_q << 3) + (est_q << 1);
        est_diff = in_num - est_back;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_valid <= 1'b0;
        end else begin
            a_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        a_quot <= est_q;
        a_rem  <= REM_EST_W'(est_diff);
    end

    // Stage B: fold one surplus divisor back into the quotient.
    logic                 over;
    logic [W-1:0]         fix_quot;
    logic [REM_EST_W-1:0] fix_rem;

    always_comb begin
        over = (a_rem >= REM_EST_W'(DIVISOR));
        if (over) begin
            fix_quot = a_quot + W'(1);
            fix_rem  = a_rem - REM_EST_W'(DIVISOR);
        end else begin
            fix_quot = a_quot;
            fix_rem  = a_rem;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= a_valid;
        end
    end

    always_ff @(posedge clk) begin
        out_quot <= fix_quot;
        out_rem  <= REM_W'(fix_rem);
    end

endmodule

// File: rtl/div10_pipe.sv
module div10_pipe
    import div10_pkg::*;
#(
    parameter int unsigned DATA_W = DIV_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] op_data,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_quot,
    output logic [REM_W-1:0]  res_rem
);

    localparam int unsigned NREF    = refine_steps(DATA_W);
    // Seed, refinements, estimate/remainder, correction.
    localparam int unsigned LATENCY = NREF + 3;

    logic              v_chain    [NREF+1];
    logic [DATA_W-1:0] num_chain  [NREF+1];
    logic [DATA_W-1:0] part_chain [NREF+1];

    div10_seed #(.W(DATA_W)) u_seed (
        .clk      (clk),
        .rst      (rst),
        .in_valid (op_valid),
        .in_num   (op_data),
        .out_valid(v_chain[0]),
        .out_num  (num_chain[0]),
        .out_part (part_chain[0])
    );

    for (genvar i = 0; i < NREF; i++) begin : g_refine
        div10_refine #(.W(DATA_W), .SHIFT(4 << i)) u_refine (
            .clk      (clk),
            .rst      (rst),
            .in_valid (v_chain[i]),
            .in_num   (num_chain[i]),
            .in_part  (part_chain[i]),
            .out_valid(v_chain[i+1]),
            .out_num  (num_chain[i+1]),
            .out_part (part_chain[i+1])
        );
    end

    div10_fix #(.W(DATA_W)) u_fix (
        .clk      (clk),
        .rst      (rst),
        .in_valid (v_chain[NREF]),
        .in_num   (num_chain[NREF]),
        .in_part  (part_chain[NREF]),
        .out_valid(res_valid),
        .out_quot (res_quot),
        .out_rem  (res_rem)
    );

endmodule

// File: rtl/div10_pipe_chk.sv
module div10_pipe_chk
    import div10_pkg::*;
#(
    parameter int unsigned DATA_W = DIV_W_DEF,
    parameter int unsigned LAT    = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [DATA_W-1:0] op_data,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_quot,
    input logic [REM_W-1:0]  res_rem
);

    logic              vsr [LAT];
    logic [DATA_W-1:0] dsr [LAT];
    logic              rst_d;
    logic [DATA_W+3:0] recon;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LAT; k++) vsr[k] <= 1'b0;
        end else begin
            vsr[0] <= op_valid;
            for (int k = 1; k < LAT; k++) vsr[k] <= vsr[k-1];
        end
    end

    always_ff @(posedge clk) begin
        dsr[0] <= op_data;
        for (int k = 1; k < LAT; k++) dsr[k] <= dsr[k-1];
        rst_d <= rst;
    end

    always_comb begin
        recon = (DATA_W+4)'(res_quot) * (DATA_W+4)'(DIVISOR) + (DATA_W+4)'(res_rem);
    end

    // R1: quotient and remainder rebuild the operand.
    assert_exact_R1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (recon == (DATA_W+4)'(dsr[LAT-1])));

    // R2: remainder below the divisor.
    assert_rem_range_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_rem < REM_W'(DIVISOR)));

    // R3, R4: result strobe exactly LAT edges after the operand strobe.
    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        res_valid == vsr[LAT-1]);

    // R5: an edge with reset high leaves no valid result.
    always_ff @(posedge clk) begin
        if (rst_d) begin
            assert_reset_flush_R5: assert (!res_valid);
        end
    end

endmodule

bind div10_pipe div10_pipe_chk #(.DATA_W(DATA_W), .LAT(LATENCY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_data  (op_data),
    .res_valid(res_valid),
    .res_quot (res_quot),
    .res_rem  (res_rem)
);

// File: tb/test_div10_pipe.sv
`timescale 1ns/1ps
module test_div10_pipe;

    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [31:0] op_data;
    logic        res_valid;
    logic [31:0] res_quot;
    logic [3:0]  res_rem;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    typedef struct {
        logic [31:0] n;
        int          due;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    div10_pipe i_div10_pipe (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_data  (op_data),
        .res_valid(res_valid),
        .res_quot (res_quot),
        .res_rem  (res_rem)
    );

    task automatic send(input logic [31:0] n);
        @(posedge clk);
        #2;
        op_valid = 1'b1;
        op_data  = n;
        sb.push_back('{n: n, due: cyc + LAT});
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            #2;
            op_valid = 1'b0;
            op_data  = $urandom;
        end
    endtask

    // Monitor: result due (R3, R6) with exact value (R1, R2, R7); otherwise silent (R4, R5).
    always @(negedge clk) begin
        if (cyc > 0 && !rst) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                item_t e;
                logic [31:0] eq;
                logic [3:0]  er;
                e  = sb.pop_front();
                eq = e.n / 32'd10;
                er = 4'(e.n % 32'd10);
                checks++;
                if (res_valid !== 1'b1) begin
                    errors++;
                    $display("FAIL R3 R6 valid for operand %0d: got %b expected 1", e.n, res_valid);
                end
                checks++;
                if (res_quot !== eq) begin
                    errors++;
                    $display("FAIL R1 R7 quotient of %0d: got %0d expected %0d", e.n, res_quot, eq);
                end
                checks++;
                if (res_rem !== er) begin
                    errors++;
                    $display("FAIL R2 R7 remainder of %0d: got %0d expected %0d", e.n, res_rem, er);
                end
            end else begin
                checks++;
                if (res_valid !== 1'b0) begin
                    errors++;
                    $display("FAIL R4 no result due at edge %0d: got %b expected 0", cyc, res_valid);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        op_valid = 1'b0;
        op_data  = '0;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R5: reset state
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R5 valid after reset: got %b expected 0", res_valid);
        end

        // R7: boundaries, back to back (R3)
        send(32'd0);
        send(32'd9);
        send(32'd10);
        send(32'd99);
        send(32'd100);
        send(32'd4294967295);
        send(32'd4294967290);
        send(32'd19);
        send(32'd20);
        idle(LAT + 2);

        // R4: sparse operands with gaps
        for (int i = 0; i < 200; i++) begin
            send($urandom);
            idle($urandom_range(0, 3));
        end

        // R1, R2, R6: dense random stream, including small values
        for (int i = 0; i < 2000; i++) begin
            if (i % 4 == 0) send($urandom_range(0, 1000));
            else send($urandom);
        end
        idle(LAT + 2);

        // R5: reset with operands in flight; those never return
        send(32'd12345);
        send(32'd67890);
        send(32'd555);
        @(posedge clk);
        #2;
        op_valid = 1'b0;
        rst      = 1'b1;
        sb.delete();
        @(posedge clk);
        #2;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R5 valid during reset: got %b expected 0", res_valid);
        end
        @(posedge clk);
        #2;
        rst = 1'b0;
        idle(LAT + 3);

        // R3: pipeline still works after reset
        send(32'd4294967295);
        send(32'd1);
        idle(LAT + 2);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R3 results outstanding: got %0d expected 0", sb.size());
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule